// File: doc/BRIEF.md
# Oversampling Serial Receiver With Interrupts

This block turns an asynchronous serial line into bytes. The frame format is chosen while the block runs. A character holds five to eight data bits. An optional odd or even parity bit follows the data, then one stop bit. The block works in one of two clock modes. With the x16 clock, every clock cycle is one sixteenth of a bit time. A falling edge opens a frame, the line is checked again half a bit later to reject glitches, and each later bit is sampled near its centre. With the x1 clock, every clock cycle is one bit time.

A finished character goes into a one-entry buffer. The buffer is read through a valid/ready stream, which also carries the parity and framing error flags. An all-low frame is reported as a break, which software polls through a status flag. The receive interrupt has three active modes: first character only, every character, and every character with parity status folded into the returned vector. A single acknowledge input clears the request. The vector is presented whenever a request is pending.

Stream rules: `rx_valid` rises when a character enters the buffer. `rx_valid` and `rx_data` stay unchanged until a cycle with `rx_ready` high. A character that completes while the buffer is full, and is not being drained in that same cycle, is discarded.

Top module: `async_rx_irq`

## Requirements
- R1: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Data bits arrive LSB first. A character is right-aligned in `rx_data`, and the bit positions above its length read 1.
- R2: With `cfg_x16`=1, a low pulse on `rx_line` shorter than 8 clocks starts no frame: no character and no break result.
- R3: With `cfg_par_en`=1, `rx_par_err` is 1 when the count of ones over the data bits and the parity bit is odd under even parity (`cfg_par_odd`=0), or even under odd parity (`cfg_par_odd`=1). Otherwise, and whenever parity is off, it is 0.
- R4: `rx_frm_err` is 1 when the stop bit is sampled low in a frame that is not a break.
- R5: A frame whose data, parity and stop bits are all low sets `brk_flag` and delivers no character. `brk_flag` clears once the line is back high.
- R6: While `rx_valid`=1 and `rx_ready`=0, `rx_valid` stays 1 and `rx_data` does not change. A cycle with `rx_ready`=1 empties the buffer.
- R7: A character that completes while the buffer is full and not being read is dropped, and the held character is kept.
- R8: With `cfg_irq_mode`=0 (off), `irq_req` never rises.
- R9: With `cfg_irq_mode`=1, only the first character received after the mode is entered raises `irq_req`. Leaving the mode and entering it again re-arms it.
- R10: With `cfg_irq_mode`=2 or 3, every character that enters the buffer raises `irq_req`. The request stays high until a cycle with `irq_ack`=1 and then drops.
- R11: `irq_vec` equals `cfg_vec_base`. The exception is mode 2 when the character that raised the request had a parity error: then bit 1 of `irq_vec` is forced to 1.
- R12: After reset, `rx_valid`, `irq_req` and `brk_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time (x1) or one sixteenth of it (x16) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length code, 0 to 3 for 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| cfg_x16 | input | 1 | 1 for the x16 clock, 0 for the x1 clock |
| cfg_irq_mode | input | 2 | 0 off, 1 first char, 2 every char with parity vector, 3 every char |
| cfg_vec_base | input | 8 | Base interrupt vector |
| rx_valid | output | 1 | Receive buffer holds a character |
| rx_ready | input | 1 | Consumer takes the character |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error of the buffered character |
| rx_frm_err | output | 1 | Framing error of the buffered character |
| brk_flag | output | 1 | Break condition seen on the line |
| irq_req | output | 1 | Interrupt request pending |
| irq_ack | input | 1 | Acknowledge; clears the request |
| irq_vec | output | 8 | Vector returned for the pending request |

## Verification
The bench builds the block with its defaults: oversampling by 16, eight-bit data and a two-stage input synchronizer. With these values, the vector table covers every character length, both clock modes and all three parity settings, with injected parity and stop-bit faults. The x16 setting makes the half-bit glitch check and the centre sampling reachable. Directed runs cover break entry and exit, buffer overrun and each interrupt mode, including re-arming of the first-character mode.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] IRQ_OFF   = 2'd0;
  localparam logic [1:0] IRQ_FIRST = 2'd1;
  localparam logic [1:0] IRQ_PVEC  = 2'd2;
  localparam logic [1:0] IRQ_ALL   = 2'd3;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rxi_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          fall,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_x16,
  output logic          done,
  output logic          brk,
  output logic [DW-1:0] data_q,
  output logic          perr_q,
  output logic          ferr_q
);
  localparam int CNT_W = $clog2(OVS);
  localparam int HALF  = OVS / 2;
  localparam int IDX_W = $clog2(DW);

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   bit_idx;
  logic [DW-1:0]      shreg;
  logic               par_acc;
  logic               any_high;
  logic               sample;
  logic [IDX_W:0]     nbits;
  logic [IDX_W-1:0]   last_idx;
  logic [IDX_W:0]     shamt;
  logic [DW-1:0]      aligned;

  assign sample   = cfg_x16 ? (cnt == CNT_W'(OVS - 1)) : 1'b1;
  assign nbits    = (IDX_W+1)'(5) + (IDX_W+1)'(cfg_len);
  assign last_idx = IDX_W'(nbits - 1'b1);
  assign shamt    = (IDX_W+1)'(DW) - nbits;

  always_comb begin
    aligned = (shreg >> shamt) | ~({DW{1'b1}} >> shamt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      any_high <= 1'b0;
      done     <= 1'b0;
      brk      <= 1'b0;
      data_q   <= '0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      brk  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            cnt      <= '0;
            bit_idx  <= '0;
            par_acc  <= 1'b0;
            any_high <= 1'b0;
            perr_q   <= 1'b0;
            state    <= cfg_x16 ? ST_START : ST_DATA;
          end
        end
        ST_START: begin
          if (cnt == CNT_W'(HALF - 1)) begin
            cnt   <= '0;
            state <= line_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (sample) begin
            cnt      <= '0;
            shreg    <= {line_s, shreg[DW-1:1]};
            par_acc  <= par_acc ^ line_s;
            any_high <= any_high | line_s;
            if (bit_idx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (sample) begin
            cnt      <= '0;
            perr_q   <= (par_acc ^ line_s) != cfg_par_odd;
            any_high <= any_high | line_s;
            state    <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (sample) begin
            cnt   <= '0;
            state <= ST_IDLE;
            if (!line_s && !any_high) begin
              brk <= 1'b1;
            end else begin
              done   <= 1'b1;
              data_q <= aligned;
              ferr_q <= ~line_s;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a break frame never also reports a character
  p_break_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !done);

  // R1: a five-bit character carries ones above its length
  p_upper_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cfg_len) == 2'd0) |-> (data_q[DW-1:5] == '1));
endmodule

// File: rtl/rx_irq.sv
module rx_irq
  import rxi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [7:0] base,
  input  logic       evt,
  input  logic       evt_perr,
  input  logic       ack,
  output logic       req,
  output logic [7:0] vec
);
  logic armed;
  logic perr_lat;
  logic raise;

  assign raise = evt && ((mode == IRQ_PVEC) || (mode == IRQ_ALL) ||
                         (mode == IRQ_FIRST && armed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      req      <= 1'b0;
      perr_lat <= 1'b0;
    end else begin
      if (mode != IRQ_FIRST) armed <= 1'b1;
      else if (evt)          armed <= 1'b0;
      if (raise) begin
        req      <= 1'b1;
        perr_lat <= evt_perr;
      end else if (ack) begin
        req <= 1'b0;
      end
    end
  end

  assign vec = {base[7:2], base[1] | ((mode == IRQ_PVEC) && perr_lat), base[0]};

  // R10: a request persists until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R8: with the interrupt off, no request appears
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IRQ_OFF && !req) |=> !req);

  // R11: outside parity-vector mode the vector is the base
  p_vec_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode != IRQ_PVEC) |-> (vec == base));
endmodule

// File: rtl/async_rx_irq.sv
module async_rx_irq
  import rxi_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_x16,
  input  logic [1:0]    cfg_irq_mode,
  input  logic [7:0]    cfg_vec_base,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_par_err,
  output logic          rx_frm_err,
  output logic          brk_flag,
  output logic          irq_req,
  input  logic          irq_ack,
  output logic [7:0]    irq_vec
);
  logic          line_s;
  logic          fall;
  logic          f_done;
  logic          f_brk;
  logic [DW-1:0] f_data;
  logic          f_perr;
  logic          f_ferr;
  logic          accept;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_s(line_s), .fall(fall)
  );

  rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .fall(fall),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_x16(cfg_x16), .done(f_done), .brk(f_brk), .data_q(f_data),
    .perr_q(f_perr), .ferr_q(f_ferr)
  );

  assign accept = f_done && (!rx_valid || rx_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      brk_flag   <= 1'b0;
    end else begin
      if (accept) begin
        rx_valid   <= 1'b1;
        rx_data    <= f_data;
        rx_par_err <= f_perr;
        rx_frm_err <= f_ferr;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (f_brk)       brk_flag <= 1'b1;
      else if (line_s) brk_flag <= 1'b0;
    end
  end

  rx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mode(cfg_irq_mode), .base(cfg_vec_base),
    .evt(accept), .evt_perr(f_perr), .ack(irq_ack), .req(irq_req), .vec(irq_vec)
  );

  // R6: a held character stays put until taken
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R5: break status drops once the line idles high
  p_brk_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && line_s && !f_brk) |=> !brk_flag);
endmodule

// File: tb/async_rx_irq_test.sv
module async_rx_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_x16 = 1'b1;
  logic [1:0] cfg_irq_mode = 2'd0;
  logic [7:0] cfg_vec_base = 8'hA0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_par_err;
  logic       rx_frm_err;
  logic       brk_flag;
  logic       irq_req;
  logic       irq_ack = 1'b0;
  logic [7:0] irq_vec;

  int n_run  = 0;
  int n_fail = 0;

  always #5ns clk = ~clk;

  async_rx_irq uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_x16(cfg_x16),
    .cfg_irq_mode(cfg_irq_mode), .cfg_vec_base(cfg_vec_base),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .brk_flag(brk_flag),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec)
  );

  // fields: x16, len, par_en, par_odd, bad_par, bad_stop, data
  localparam logic [14:0] VEC [9] = '{
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h13},
    {1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55},
    {1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C},
    {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2A},
    {1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h81},
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h7F},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h21},
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0A}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int cyc);
    rx_line = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int per = cfg_x16 ? 16 : 1;
    int nb  = 5 + int'(cfg_len);
    logic p = 1'b0;
    hold_line(1'b0, per);
    for (int i = 0; i < nb; i++) begin
      p ^= d[i];
      hold_line(d[i], per);
    end
    if (cfg_par_en) hold_line(p ^ cfg_par_odd ^ bad_par, per);
    hold_line(~bad_stop, per);
    hold_line(1'b1, 2 * per + 4);
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (rx_valid) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic take();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  function automatic logic [7:0] expect_data(input logic [7:0] d, input logic [1:0] len);
    logic [7:0] m = 8'hFF >> (3 - len);
    return (d & m) | ~m;
  endfunction

  initial begin
    #2ms;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(!rx_valid && !irq_req && !brk_flag, "R12 reset outputs",
          {rx_valid, irq_req, brk_flag}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R3 R4: table of formats and faults
    for (int k = 0; k < 9; k++) begin
      logic [14:0] v = VEC[k];
      logic [9:0]  exp;
      cfg_x16     = v[14];
      cfg_len     = v[13:12];
      cfg_par_en  = v[11];
      cfg_par_odd = v[10];
      repeat (4) @(negedge clk);
      send(v[7:0], v[9], v[8]);
      wait_valid(got);
      exp = {expect_data(v[7:0], v[13:12]), v[9] & v[11], v[8]};
      check(got && ({rx_data, rx_par_err, rx_frm_err} == exp),
            "R1/R3/R4 table entry", {22'd0, rx_data, rx_par_err, rx_frm_err}, {22'd0, exp});
      take();
    end

    cfg_x16 = 1'b1; cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    repeat (4) @(negedge clk);

    // R2: short glitch ignored, following frame still good
    hold_line(1'b0, 3);
    hold_line(1'b1, 80);
    check(!rx_valid && !brk_flag, "R2 glitch rejected", {rx_valid, brk_flag}, 0);
    send(8'h5A, 1'b0, 1'b0);
    wait_valid(got);
    check(got && rx_data == 8'h5A, "R2 frame after glitch", rx_data, 8'h5A);
    take();

    // R5: break
    hold_line(1'b0, 16 * 12);
    check(brk_flag && !rx_valid, "R5 break sets flag, no char", {brk_flag, rx_valid}, 2'b10);
    hold_line(1'b1, 6);
    check(!brk_flag, "R5 break clears on idle", brk_flag, 0);
    hold_line(1'b1, 20);

    // R6 R7: hold and overrun
    send(8'hC3, 1'b0, 1'b0);
    wait_valid(got);
    send(8'h3C, 1'b0, 1'b0);
    check(rx_valid && rx_data == 8'hC3, "R6/R7 held char kept", rx_data, 8'hC3);
    take();
    repeat (30) @(negedge clk);
    check(!rx_valid, "R7 overrun char dropped", rx_valid, 0);

    // R8: interrupt off
    check(!irq_req, "R8 no request when off", irq_req, 0);

    // R9: first character only, then re-arm
    cfg_irq_mode = 2'd1;
    send(8'h11, 1'b0, 1'b0);
    wait_valid(got);
    check(irq_req, "R9 first char raises", irq_req, 1);
    ack(); take();
    send(8'h22, 1'b0, 1'b0);
    wait_valid(got);
    check(got && !irq_req, "R9 second char silent", irq_req, 0);
    take();
    cfg_irq_mode = 2'd0;
    @(negedge clk);
    cfg_irq_mode = 2'd1;
    send(8'h33, 1'b0, 1'b0);
    wait_valid(got);
    check(irq_req, "R9 re-armed after re-entry", irq_req, 1);
    ack(); take();

    // R10 R11: parity-vector mode
    cfg_irq_mode = 2'd2;
    send(8'h44, 1'b1, 1'b0);
    wait_valid(got);
    check(irq_vec == 8'hA2, "R11 vector bit1 on parity error", irq_vec, 8'hA2);
    repeat (10) @(negedge clk);
    check(irq_req, "R10 request held until ack", irq_req, 1);
    ack();
    check(!irq_req, "R10 ack clears request", irq_req, 0);
    take();
    send(8'h45, 1'b0, 1'b0);
    wait_valid(got);
    check(irq_req && irq_vec == 8'hA0, "R11 vector clean parity", irq_vec, 8'hA0);
    ack(); take();

    // R10 R11: every-char mode ignoring parity
    cfg_irq_mode = 2'd3;
    send(8'h46, 1'b1, 1'b0);
    wait_valid(got);
    check(irq_req && irq_vec == 8'hA0, "R11 vector ignores parity", irq_vec, 8'hA0);
    ack(); take();
    send(8'h47, 1'b0, 1'b0);
    wait_valid(got);
    check(irq_req, "R10 every char raises", irq_req, 1);
    ack(); take();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule